// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the outgoing half of the controller end of a serial audio codec link. It runs entirely on the codec bit clock, which is nominally 12.288 MHz. It builds one 256-bit frame every 256 bit periods, which gives a 48 kHz frame rate. Each frame has a 16-bit tag slot followed by twelve 20-bit data slots. The frame is shifted out on a single serial line, and a frame-sync strobe is driven alongside it. Reset is synchronous and active-high.

Two request streams feed the frames, each through a valid/ready handshake. The first stream carries register commands: a read flag, a 7-bit register index and 16 bits of write data. The second carries stereo playback samples, a left and a right 16-bit word. Requests are accepted only in the last bit period of a frame. An accepted request is placed in the frame that starts on the next edge, and in no later frame.

The tag marks each slot that carries data. It also carries a frame-valid flag and a 3-bit codec identifier. All other slots are driven to zero.

Top module: `link_frame_tx`

## Requirements
- R1: A frame lasts 256 bit periods. `sync` rises once every 256 cycles.
- R2: `sync` is high for the 16 bit periods of the tag slot (positions 0..15) and low for the 240 data positions (16..255).
- R3: Tag bit 15 (frame position 0) is 1 exactly when at least one slot-valid flag in that frame is set.
- R4: Tag bits 14..3 are the valid flags of slots 1..12, with slot 1 in bit 14. Tag bits 2..0 carry the value of `codec_id` sampled at the frame boundary.
- R5: In a frame with an accepted command, slot 1 is set as follows. Bit 19 is `cmd_read` (1 = read). Bits 18..12 are `cmd_index`. Bits 11..0 are zero. The slot 1 valid flag is set.
- R6: Slot 2 carries `cmd_wdata` in bits 19..4 with bits 3..0 zero, and has its valid flag set, only for an accepted write. For a read, or when no command is taken, slot 2 and its flag are zero.
- R7: In a frame with an accepted sample pair, slot 3 carries `pcm_left` and slot 4 carries `pcm_right`, each in bits 19..4 with bits 3..0 zero. The valid flags of slots 3 and 4 are set. Without a sample, both slots and both flags are zero.
- R8: Slots 5..12 and their valid flags (tag bits 10..3) are always zero.
- R9: Each slot goes out most significant bit first, with the tag first. `sdata_out` and `sync` change only on the rising clock edge (both are registered).
- R10: `cmd_ready` and `pcm_ready` are high only in the last bit period of a frame. Requests presented at any other time are ignored and leave the frames unchanged.
- R11: Each accepted request appears in exactly one frame. A following frame with no new request has every slot-valid flag clear.
- R12: While `rst` is high, `sync`, `sdata_out` and both ready outputs are 0. The first frame starts on the first rising edge after `rst` falls, so `sync` is high in the bit period that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_index | input | 7 | Register index |
| cmd_wdata | input | 16 | Register write data |
| pcm_valid | input | 1 | Sample pair present |
| pcm_ready | output | 1 | Sample pair accepted this cycle when valid |
| pcm_left | input | 16 | Left playback sample |
| pcm_right | input | 16 | Right playback sample |
| codec_id | input | 3 | Codec identifier placed in the tag |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdata_out | output | 1 | Serial frame data, MSB first |

## Verification
Frames are captured whole and decoded field by field under several input patterns:
- An empty frame.
- A write command alone, and a read command alone. Comparing these shows whether slot 2 and its flag depend on the read flag.
- A sample pair alone.
- A write and a sample pair together, with a non-zero codec identifier.
- An identifier-only frame. This separates the identifier bits from the frame-valid flag.

All-ones and sign-extreme data expose any leakage into the zero nibbles. An empty frame right after a loaded one shows whether a request is consumed once or repeated. Requests held only in the middle of a frame show whether the boundary-only acceptance holds.

// File: rtl/lft_pkg.sv
package lft_pkg;

  localparam int DEF_NUM_SLOTS = 12;
  localparam int DEF_SLOT_W    = 20;
  localparam int DEF_IDX_W     = 7;
  localparam int DEF_CMD_W     = 16;
  localparam int DEF_PCM_W     = 16;
  localparam int DEF_ID_W      = 3;

  // Bit position, inside the frame vector (MSB sent first), of the top bit of slot k.
  function automatic int slot_msb(input int frame_w, input int tag_w,
                                  input int slot_w, input int k);
    return frame_w - 1 - tag_w - (k - 1) * slot_w;
  endfunction

endpackage

// File: rtl/lft_pos_counter.sv
module lft_pos_counter #(
  parameter int FRAME_W = 256,
  parameter int TAG_W   = 16,
  localparam int POS_W  = $clog2(FRAME_W)
) (
  input  logic clk,
  input  logic rst,
  output logic boundary,
  output logic sync
);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] next_pos;

  assign boundary = (pos == POS_W'(FRAME_W - 1)) && !rst;
  assign next_pos = (pos == POS_W'(FRAME_W - 1)) ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= POS_W'(FRAME_W - 1);
      sync <= 1'b0;
    end else begin
      pos  <= next_pos;
      sync <= (next_pos < POS_W'(TAG_W));
    end
  end

endmodule

// File: rtl/lft_frame_build.sv
module lft_frame_build #(
  parameter int NUM_SLOTS = lft_pkg::DEF_NUM_SLOTS,
  parameter int SLOT_W    = lft_pkg::DEF_SLOT_W,
  parameter int IDX_W     = lft_pkg::DEF_IDX_W,
  parameter int CMD_W     = lft_pkg::DEF_CMD_W,
  parameter int PCM_W     = lft_pkg::DEF_PCM_W,
  parameter int ID_W      = lft_pkg::DEF_ID_W,
  localparam int TAG_W    = 1 + NUM_SLOTS + ID_W,
  localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W
) (
  input  logic               cmd_take,
  input  logic               cmd_read,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic [CMD_W-1:0]   cmd_wdata,
  input  logic               pcm_take,
  input  logic [PCM_W-1:0]   pcm_left,
  input  logic [PCM_W-1:0]   pcm_right,
  input  logic [ID_W-1:0]    codec_id,
  output logic [FRAME_W-1:0] frame
);

  // Slot valid flags, slot 1 in the most significant bit.
  logic [NUM_SLOTS-1:0] vld;

  for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_slot
    localparam int MSB = lft_pkg::slot_msb(FRAME_W, TAG_W, SLOT_W, k);
    localparam int VB  = NUM_SLOTS - k;
    if (k == 1) begin : g_addr
      assign vld[VB] = cmd_take;
      assign frame[MSB -: SLOT_W] = cmd_take ?
        {cmd_read, cmd_index, {(SLOT_W - 1 - IDX_W){1'b0}}} : '0;
    end else if (k == 2) begin : g_wdata
      assign vld[VB] = cmd_take & ~cmd_read;
      assign frame[MSB -: SLOT_W] = vld[VB] ?
        {cmd_wdata, {(SLOT_W - CMD_W){1'b0}}} : '0;
    end else if (k == 3) begin : g_left
      assign vld[VB] = pcm_take;
      assign frame[MSB -: SLOT_W] = pcm_take ?
        {pcm_left, {(SLOT_W - PCM_W){1'b0}}} : '0;
    end else if (k == 4) begin : g_right
      assign vld[VB] = pcm_take;
      assign frame[MSB -: SLOT_W] = pcm_take ?
        {pcm_right, {(SLOT_W - PCM_W){1'b0}}} : '0;
    end else begin : g_idle
      assign vld[VB] = 1'b0;
      assign frame[MSB -: SLOT_W] = '0;
    end
  end

  assign frame[FRAME_W-1 -: TAG_W] = {|vld, vld, codec_id};

endmodule

// File: rtl/lft_shifter.sv
module lft_shifter #(
  parameter int FRAME_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sdata
);

  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      sdata <= 1'b0;
    end else if (load) begin
      sdata <= frame_in[FRAME_W-1];
      shreg <= {frame_in[FRAME_W-2:0], 1'b0};
    end else begin
      sdata <= shreg[FRAME_W-1];
      shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx #(
  parameter int NUM_SLOTS = lft_pkg::DEF_NUM_SLOTS,
  parameter int SLOT_W    = lft_pkg::DEF_SLOT_W,
  parameter int IDX_W     = lft_pkg::DEF_IDX_W,
  parameter int CMD_W     = lft_pkg::DEF_CMD_W,
  parameter int PCM_W     = lft_pkg::DEF_PCM_W,
  parameter int ID_W      = lft_pkg::DEF_ID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_read,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             pcm_valid,
  output logic             pcm_ready,
  input  logic [PCM_W-1:0] pcm_left,
  input  logic [PCM_W-1:0] pcm_right,
  input  logic [ID_W-1:0]  codec_id,
  output logic             sync,
  output logic             sdata_out
);

  localparam int TAG_W   = 1 + NUM_SLOTS + ID_W;
  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;

  logic               boundary;
  logic [FRAME_W-1:0] next_frame;

  lft_pos_counter #(.FRAME_W(FRAME_W), .TAG_W(TAG_W)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .sync     (sync)
  );

  assign cmd_ready = boundary;
  assign pcm_ready = boundary;

  lft_frame_build #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W),
    .CMD_W(CMD_W), .PCM_W(PCM_W), .ID_W(ID_W)
  ) u_build (
    .cmd_take  (cmd_valid & boundary),
    .cmd_read  (cmd_read),
    .cmd_index (cmd_index),
    .cmd_wdata (cmd_wdata),
    .pcm_take  (pcm_valid & boundary),
    .pcm_left  (pcm_left),
    .pcm_right (pcm_right),
    .codec_id  (codec_id),
    .frame     (next_frame)
  );

  lft_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (boundary),
    .frame_in (next_frame),
    .sdata    (sdata_out)
  );

endmodule

// File: rtl/lft_checks.sv
module lft_checks #(
  parameter int NUM_SLOTS = lft_pkg::DEF_NUM_SLOTS,
  parameter int SLOT_W    = lft_pkg::DEF_SLOT_W,
  parameter int ID_W      = lft_pkg::DEF_ID_W,
  localparam int TAG_W    = 1 + NUM_SLOTS + ID_W,
  localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W,
  localparam int POS_W    = $clog2(FRAME_W)
) (
  input logic clk,
  input logic rst,
  input logic sync,
  input logic sdata_out,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic pcm_valid,
  input logic pcm_ready
);

  // Independent position tracker, started by the first rising sync after reset.
  logic             started;
  logic             sync_d;
  logic [POS_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      sync_d  <= 1'b0;
      ph      <= '0;
    end else begin
      sync_d <= sync;
      if (!started) begin
        if (sync && !sync_d) begin
          started <= 1'b1;
          ph      <= POS_W'(1);
        end
      end else begin
        ph <= (ph == POS_W'(FRAME_W - 1)) ? '0 : ph + 1'b1;
      end
    end
  end

  p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
    (started && $rose(sync)) |-> (ph == '0));

  p_sync_shape_r2: assert property (@(posedge clk) disable iff (rst)
    started |-> (sync == (ph < POS_W'(TAG_W))));

  p_fv_set_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync) && $past((cmd_valid && cmd_ready) || (pcm_valid && pcm_ready)))
      |-> sdata_out);

  p_fv_clear_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync) && $past(!(cmd_valid && cmd_ready) && !(pcm_valid && pcm_ready)))
      |-> !sdata_out);

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (started && (((ph >= POS_W'(5)) && (ph <= POS_W'(NUM_SLOTS))) ||
                 (ph >= POS_W'(TAG_W + 4 * SLOT_W)))) |-> !sdata_out);

  p_ready_edge_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready || pcm_ready) |=> $rose(sync));

  p_reset_out_r12: assert property (@(posedge clk)
    rst |=> (!sync && !sdata_out));

endmodule

bind link_frame_tx lft_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .sync      (sync),
  .sdata_out (sdata_out),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .pcm_valid (pcm_valid),
  .pcm_ready (pcm_ready)
);

// File: tb/link_frame_tx_test.sv
module link_frame_tx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_read = 1'b0;
  logic [6:0]  cmd_index = '0;
  logic [15:0] cmd_wdata = '0;
  logic        pcm_valid = 1'b0;
  logic        pcm_ready;
  logic [15:0] pcm_left = '0;
  logic [15:0] pcm_right = '0;
  logic [2:0]  codec_id = '0;
  logic        sync;
  logic        sdata_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_frame_tx uut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_index(cmd_index), .cmd_wdata(cmd_wdata),
    .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
    .pcm_left(pcm_left), .pcm_right(pcm_right),
    .codec_id(codec_id), .sync(sync), .sdata_out(sdata_out)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected frame built from the field layout in the requirements.
  function automatic logic [255:0] expect_frame(
      input bit c, input bit rd, input logic [6:0] idx, input logic [15:0] wd,
      input bit p, input logic [15:0] l, input logic [15:0] r, input logic [2:0] id);
    logic [255:0] f;
    logic [11:0]  v;
    v = {c, c & ~rd, p, p, 8'h00};
    f = '0;
    f[255]     = |v;
    f[254:243] = v;
    f[242:240] = id;
    if (c)       f[239:220] = {rd, idx, 12'h000};
    if (c && !rd) f[219:200] = {wd, 4'h0};
    if (p) begin
      f[199:180] = {l, 4'h0};
      f[179:160] = {r, 4'h0};
    end
    return f;
  endfunction

  // Present requests, wait for the boundary, then capture and decode one frame.
  task automatic run_frame(input string tag,
      input bit c, input bit rd, input logic [6:0] idx, input logic [15:0] wd,
      input bit p, input logic [15:0] l, input logic [15:0] r, input logic [2:0] id);
    logic [255:0] got;
    logic [255:0] exp;
    int bad_sync;
    cmd_valid = c;  cmd_read = rd; cmd_index = idx; cmd_wdata = wd;
    pcm_valid = p;  pcm_left = l;  pcm_right = r;   codec_id = id;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    pcm_valid = 1'b0;
    bad_sync = 0;
    for (int i = 0; i < 256; i++) begin
      got[255 - i] = sdata_out;
      if (sync !== (i < 16)) bad_sync++;
      @(negedge clk);
    end
    exp = expect_frame(c, rd, idx, wd, p, l, r, id);
    check({tag, " R3 R4 R9"}, "tag", 64'(got[255:240]), 64'(exp[255:240]));
    check({tag, " R5 R9"}, "slot1", 64'(got[239:220]), 64'(exp[239:220]));
    check({tag, " R6"}, "slot2", 64'(got[219:200]), 64'(exp[219:200]));
    check({tag, " R7"}, "slots3-4", 64'(got[199:160]), 64'(exp[199:160]));
    check({tag, " R8"}, "upper slots ones", 64'($countones(got[159:0])), 64'd0);
    check({tag, " R2"}, "sync shape errors", 64'(bad_sync), 64'd0);
    check({tag, " R1"}, "next frame sync", 64'(sync), 64'd1);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check("R12", "sync in reset", 64'(sync), 64'd0);
    check("R12", "sdata in reset", 64'(sdata_out), 64'd0);
    check("R12", "ready in reset", 64'({cmd_ready, pcm_ready}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R12", "sync after first edge", 64'(sync), 64'd1);
  endtask

  task automatic t_idle;
    run_frame("idle", 0, 0, 7'h00, 16'h0000, 0, 16'h0, 16'h0, 3'd0);
  endtask

  task automatic t_write;
    run_frame("write", 1, 0, 7'h2C, 16'hBB80, 0, 16'h0, 16'h0, 3'd0);
  endtask

  task automatic t_consume_r11;
    run_frame("R11 after", 0, 0, 7'h00, 16'h0000, 0, 16'h0, 16'h0, 3'd0);
  endtask

  task automatic t_read;
    run_frame("read", 1, 1, 7'h7F, 16'hFFFF, 0, 16'h0, 16'h0, 3'd0);
  endtask

  task automatic t_pcm;
    run_frame("pcm", 0, 0, 7'h00, 16'h0000, 1, 16'h8000, 16'h7FFF, 3'd0);
  endtask

  task automatic t_both;
    run_frame("both", 1, 0, 7'h02, 16'h0808, 1, 16'h1234, 16'hFEDC, 3'd5);
  endtask

  task automatic t_id_only;
    run_frame("id", 0, 0, 7'h00, 16'h0000, 0, 16'h0, 16'h0, 3'd7);
  endtask

  // R10: requests held only mid-frame are not taken and do not reach the next frame.
  task automatic t_ignore_r10;
    int early_ready;
    int wait_cnt;
    early_ready = 0;
    cmd_valid = 1'b1; cmd_read = 1'b0; cmd_index = 7'h55; cmd_wdata = 16'hA5A5;
    pcm_valid = 1'b1; pcm_left = 16'hFFFF; pcm_right = 16'hFFFF;
    for (int i = 0; i < 20; i++) begin
      if (cmd_ready || pcm_ready) early_ready++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    pcm_valid = 1'b0;
    check("R10", "ready mid-frame", 64'(early_ready), 64'd0);
    wait_cnt = 0;
    while (!cmd_ready) begin
      wait_cnt++;
      @(negedge clk);
    end
    check("R10", "ready position", 64'(wait_cnt), 64'd235);
    run_frame("R10 ignored", 0, 0, 7'h00, 16'h0000, 0, 16'h0, 16'h0, 3'd0);
  endtask

  initial begin
    t_reset;
    t_idle;
    t_write;
    t_consume_r11;
    t_read;
    t_pcm;
    t_both;
    t_id_only;
    t_ignore_r10;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule